// File: doc/BRIEF.md
# Stipple and Blit Pixel Engine

This block is a small drawing accelerator that sits between a register bus and a pixel memory. The pixel memory holds an 8-bit colour-index plane, an optional 32-bit direct-colour plane and an optional 32-bit control plane, all indexed by the same pixel number. Software drives the engine with pairs of writes. The first write of a pair stores a colour in the engine. The second write starts an operation. Its bus address carries the destination pixel and its data word carries the operation parameters.

Four register windows pick the operation. The masked-stipple windows paint the stored colour into any subset of 32 consecutive pixels, chosen by a bit mask. The blit windows either fill a run of 1 to 32 pixels with the stored colour or copy a run from a source pixel. A source field with every bit set selects the fill. The two raw windows behave like their plain counterparts and also update the control plane. A depth input turns on the wide planes. With depth off, only the 8-bit plane is touched.

The engine handles one pixel per cycle. It holds its register port not-ready until the run is over, so software needs no polling. Copies run in ascending pixel order with exact sequential semantics, which makes overlapping moves deterministic.

Top module: `pixop_engine`

## Requirements
- R1: A bus write whose address bit 2 is 0 only stores the 32-bit data word as the current colour. It raises no busy and makes no memory access.
- R2: A bus write with address bit 2 set starts an operation whose destination pixel is address bits 22:3. The window input selects it: 0 plain stipple, 1 plain blit, 2 raw stipple, 3 raw blit.
- R3: Stipple writes colour bits 7:0 to destination pixel +k for every k where data bit (31-k) is 1, and leaves every other pixel alone. It is busy for exactly as many cycles as the mask has set bits, so an all-zero mask raises no busy and writes nothing.
- R4: Blit run length is data bits 28:24 plus one (1 to 32). When data bits 23:0 are 0xFFFFFF, the run is filled with the colour and the engine is busy for exactly that many cycles.
- R5: Any other source value copies the run from source pixel bits 23:0 to the destination. Pixels are handled in ascending order, each read seeing every earlier write of the same run, so a destination one above the source replicates the first source pixel. A copy is busy for run length plus one cycles.
- R6: With the depth input high, the 32-bit plane gets {8'h00, colour[23:0]} on stipple and fill and is copied alongside the 8-bit plane on copy. With it low, the 32-bit plane is never written.
- R7: The raw windows (window bit 1 set) also write or copy the control plane with the same value as the 32-bit plane, and only when the depth input is high. The plain windows never write it.
- R8: A bus read returns zero and has no side effect: no busy, no memory access, colour unchanged.
- R9: After reset, busy is low, ready is high and no memory access is made. Ready is low on every cycle in which busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| deep_en | input | 1 | Enables the 32-bit and control planes; sampled when an operation starts |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_win | input | 2 | Window: 0 stipple, 1 blit, 2 raw stipple, 3 raw blit |
| req_addr | input | 23 | Byte offset inside the window; bit 2 selects colour or start, bits 22:3 the destination |
| req_wdata | input | 32 | Colour, stipple mask, or source and length |
| req_ready | output | 1 | Request accepted on a cycle where valid and ready are both high |
| rsp_rdata | output | 32 | Read data, always zero |
| busy | output | 1 | A pixel run is in progress |
| mem_rd_en | output | 1 | Pixel read request, data returned one cycle later |
| mem_rd_addr | output | 24 | Pixel read index |
| mem_rd_pix | input | 8 | 8-bit plane read data |
| mem_rd_p32 | input | 32 | 32-bit plane read data |
| mem_rd_ctl | input | 32 | Control plane read data |
| mem_wr_en | output | 1 | 8-bit plane write |
| mem_wr_addr | output | 24 | Pixel write index for all planes |
| mem_wr_pix | output | 8 | 8-bit plane write data |
| mem_wr_p32_en | output | 1 | 32-bit plane write |
| mem_wr_p32 | output | 32 | 32-bit plane write data |
| mem_wr_ctl_en | output | 1 | Control plane write |
| mem_wr_ctl | output | 32 | Control plane write data |

## Verification
Stipple runs with sparse, dense and empty masks separate a correct bit-to-pixel order from a reversed one. The busy length reveals whether clear bits cost cycles. Fills at the shortest and longest run lengths catch an off-by-one in the length field. Copies go to a disjoint target, to a target one pixel above the source (which must replicate the first pixel) and to one pixel below (which must shift). Together these expose a missing or wrong read-after-write forward. The same patterns repeated with the depth input high, through plain and raw windows, tell apart which planes each window may touch, and interleaved colour stores and reads confirm that neither disturbs memory.

// File: rtl/pixop_pkg.sv
// Shared types for the stipple/blit pixel engine.
// Assumes one 8-bit index plane and two 32-bit side planes per pixel.
package pixop_pkg;
    localparam int PIX_W  = 8;
    localparam int WIDE_W = 32;
    localparam int RGB_W  = 24;

    // Register window selected by the bus decoder in front of the engine
    typedef enum logic [1:0] {
        WIN_STIP  = 2'd0,
        WIN_BLIT  = 2'd1,
        WIN_RSTIP = 2'd2,
        WIN_RBLIT = 2'd3
    } win_e;

    // Sequencer state
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STIP = 2'd1,
        ST_FILL = 2'd2,
        ST_COPY = 2'd3
    } run_e;

    // One pixel across all three planes
    typedef struct packed {
        logic [PIX_W-1:0]  pix;
        logic [WIDE_W-1:0] p32;
        logic [WIDE_W-1:0] ctl;
    } pel_t;
endpackage

// File: rtl/pixop_bitpick.sv
// Finds the most significant set bit of a stipple mask, reports it as an
// offset counted from the MSB (MSB -> 0) and returns the mask without it.
// Assumes the caller only uses off_o while any_o is high.
module pixop_bitpick #(
    parameter int MASK_W = 32,
    localparam int OFF_W = $clog2(MASK_W)
) (
    input  logic [MASK_W-1:0] mask_i,
    output logic              any_o,
    output logic [OFF_W-1:0]  off_o,
    output logic [MASK_W-1:0] rest_o
);
    logic [MASK_W-1:0] above;   // some higher bit is set
    logic [MASK_W-1:0] first;   // one-hot highest set bit

    assign above[MASK_W-1] = 1'b0;
    genvar g;
    generate
        for (g = 0; g < MASK_W - 1; g++) begin : g_chain
            assign above[g] = above[g+1] | mask_i[g+1];
        end
        for (g = 0; g < MASK_W; g++) begin : g_first
            assign first[g] = mask_i[g] & ~above[g];
        end
    endgenerate

    // Encode the one-hot pick as an MSB-relative offset
    always_comb begin
        off_o = '0;
        for (int i = 0; i < MASK_W; i++) begin
            if (first[i]) off_o = OFF_W'(MASK_W - 1 - i);
        end
    end

    assign any_o  = |mask_i;
    assign rest_o = mask_i & ~first;
endmodule

// File: rtl/pixop_fwd.sv
// Copy read stage: returns the source pixel for the write issued one cycle
// after its read. If the read hit the pixel being written in that same
// cycle, the memory returns stale data, so the written value is replayed.
// Assumes a memory with one-cycle read latency and read-before-write.
module pixop_fwd
    import pixop_pkg::*;
#(
    parameter int MEM_AW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  logic [MEM_AW-1:0] rd_addr_i,
    input  logic              wr_en_i,
    input  logic [MEM_AW-1:0] wr_addr_i,
    input  pel_t              wr_pel_i,
    input  pel_t              mem_pel_i,
    output pel_t              src_pel_o
);
    logic hit_q;
    pel_t hold_q;

    // Record whether this read collides with the concurrent write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            hold_q <= '0;
        end else if (rd_en_i) begin
            hit_q  <= wr_en_i && (wr_addr_i == rd_addr_i);
            hold_q <= wr_pel_i;
        end else begin
            hit_q  <= 1'b0;
        end
    end

    assign src_pel_o = hit_q ? hold_q : mem_pel_i;

    // R5: a forwarded value always stems from a read issued the cycle before
    fwd_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> $past(rd_en_i) && $past(wr_en_i));
endmodule

// File: rtl/pixop_seq.sv
// Run sequencer: walks a stipple mask, a fill run or a copy run one pixel
// per cycle and drives the pixel-memory port. Launch pulses are only
// presented while idle; the colour input stays stable during a run.
module pixop_seq
    import pixop_pkg::*;
#(
    parameter int MEM_AW = 24,
    parameter int MASK_W = 32,
    localparam int LEN_W = $clog2(MASK_W),
    localparam int RUNC_W = LEN_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_stip_i,
    input  logic              go_blit_i,
    input  logic              raw_i,
    input  logic              deep_i,
    input  logic [MEM_AW-1:0] dst_i,
    input  logic [MEM_AW-1:0] src_i,
    input  logic [LEN_W-1:0]  len_m1_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic [WIDE_W-1:0] color_i,
    output logic [MASK_W-1:0] mask_o,
    input  logic [LEN_W-1:0]  pick_off_i,
    input  logic [MASK_W-1:0] pick_rest_i,
    input  pel_t              copy_pel_i,
    output logic              busy_o,
    output logic              rd_en_o,
    output logic [MEM_AW-1:0] rd_addr_o,
    output logic              wr_en_o,
    output logic [MEM_AW-1:0] wr_addr_o,
    output pel_t              wr_pel_o,
    output logic              wr_p32_en_o,
    output logic              wr_ctl_en_o
);
    run_e              state_q;
    logic [MEM_AW-1:0] dst_q, src_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [MASK_W-1:0] mask_q;
    logic              raw_q, deep_q, rd_on_q, wr_vld_q;
    pel_t              solid;
    logic [WIDE_W-RGB_W-1:0] unused_color_hi;

    assign unused_color_hi = color_i[WIDE_W-1:RGB_W];
    assign mask_o = mask_q;

    // Pixel value used by stipple and fill
    always_comb begin
        solid.pix = color_i[PIX_W-1:0];
        solid.p32 = {{(WIDE_W-RGB_W){1'b0}}, color_i[RGB_W-1:0]};
        solid.ctl = {{(WIDE_W-RGB_W){1'b0}}, color_i[RGB_W-1:0]};
    end

    // Memory port drive for the current state
    always_comb begin
        busy_o    = (state_q != ST_IDLE);
        rd_en_o   = (state_q == ST_COPY) && rd_on_q;
        rd_addr_o = src_q;
        wr_en_o   = 1'b0;
        wr_addr_o = dst_q;
        wr_pel_o  = solid;
        case (state_q)
            ST_STIP: begin
                wr_en_o   = 1'b1;
                wr_addr_o = dst_q + MEM_AW'(pick_off_i);
            end
            ST_FILL: wr_en_o = 1'b1;
            ST_COPY: begin
                wr_en_o  = wr_vld_q;
                wr_pel_o = copy_pel_i;
            end
            default: wr_en_o = 1'b0;
        endcase
        wr_p32_en_o = wr_en_o && deep_q;
        wr_ctl_en_o = wr_en_o && deep_q && raw_q;
    end

    // Run state, pointers and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            dst_q    <= '0;
            src_q    <= '0;
            cnt_q    <= '0;
            mask_q   <= '0;
            raw_q    <= 1'b0;
            deep_q   <= 1'b0;
            rd_on_q  <= 1'b0;
            wr_vld_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    raw_q  <= raw_i;
                    deep_q <= deep_i;
                    dst_q  <= dst_i;
                    if (go_stip_i && (mask_i != '0)) begin
                        mask_q  <= mask_i;
                        state_q <= ST_STIP;
                    end else if (go_blit_i) begin
                        src_q    <= src_i;
                        cnt_q    <= len_m1_i;
                        rd_on_q  <= 1'b1;
                        wr_vld_q <= 1'b0;
                        state_q  <= (&src_i) ? ST_FILL : ST_COPY;
                    end
                end
                ST_STIP: begin
                    mask_q <= pick_rest_i;
                    if (pick_rest_i == '0) state_q <= ST_IDLE;
                end
                ST_FILL: begin
                    dst_q <= dst_q + 1'b1;
                    if (cnt_q == '0) state_q <= ST_IDLE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                ST_COPY: begin
                    if (rd_on_q) begin
                        src_q <= src_q + 1'b1;
                        if (cnt_q == '0) rd_on_q <= 1'b0;
                        else             cnt_q   <= cnt_q - 1'b1;
                    end
                    wr_vld_q <= rd_on_q;
                    if (wr_vld_q) dst_q <= dst_q + 1'b1;
                    if (wr_vld_q && !rd_on_q) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Checker state: length of the current busy stretch
    logic [RUNC_W-1:0] run_len_q;
    always_ff @(posedge clk) begin
        if (!rst_n)       run_len_q <= '0;
        else if (busy_o)  run_len_q <= run_len_q + 1'b1;
        else              run_len_q <= '0;
    end

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !wr_en_o && !rd_en_o);
    // R3
    pick_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STIP) |-> mask_q[MASK_W-1-int'(pick_off_i)]);
    // R5
    wr_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && $past(busy_o) && wr_en_o && $past(wr_en_o)
        |-> wr_addr_o > $past(wr_addr_o));
    // R7
    ctl_needs_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl_en_o |-> wr_p32_en_o && wr_en_o);
    // R4
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_len_q <= RUNC_W'(MASK_W + 1));
endmodule

// File: rtl/pixop_engine.sv
// Stipple/blit pixel engine top: decodes the register port into colour
// stores and operation launches, and ties the sequencer, mask picker and
// copy forwarding stage to the pixel-memory port.
// Assumes the pixel memory reads with one cycle of latency.
module pixop_engine
    import pixop_pkg::*;
#(
    parameter int DST_W  = 20,
    parameter int MEM_AW = 24,
    parameter int MASK_W = 32,
    localparam int LEN_W  = $clog2(MASK_W),
    localparam int ADDR_W = DST_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deep_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_win,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WIDE_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [WIDE_W-1:0] rsp_rdata,
    output logic              busy,
    output logic              mem_rd_en,
    output logic [MEM_AW-1:0] mem_rd_addr,
    input  logic [PIX_W-1:0]  mem_rd_pix,
    input  logic [WIDE_W-1:0] mem_rd_p32,
    input  logic [WIDE_W-1:0] mem_rd_ctl,
    output logic              mem_wr_en,
    output logic [MEM_AW-1:0] mem_wr_addr,
    output logic [PIX_W-1:0]  mem_wr_pix,
    output logic              mem_wr_p32_en,
    output logic [WIDE_W-1:0] mem_wr_p32,
    output logic              mem_wr_ctl_en,
    output logic [WIDE_W-1:0] mem_wr_ctl
);
    logic [WIDE_W-1:0] color_q;
    logic              take_wr, store_color, go_stip, go_blit;
    logic [MASK_W-1:0] mask_cur, pick_rest;
    logic [LEN_W-1:0]  pick_off;
    logic              pick_any;
    logic [1:0]        unused_lsb;
    pel_t              mem_pel, copy_pel, wr_pel;

    assign unused_lsb = req_addr[1:0];

    // Register port decode
    assign take_wr     = req_valid && req_ready && req_write;
    assign store_color = take_wr && !req_addr[2];
    assign go_stip     = take_wr && req_addr[2] && !req_win[0];
    assign go_blit     = take_wr && req_addr[2] &&  req_win[0];
    assign req_ready   = !busy;
    assign rsp_rdata   = '0;

    // Colour latch, written by the first access of each pair
    always_ff @(posedge clk) begin
        if (!rst_n)           color_q <= '0;
        else if (store_color) color_q <= req_wdata;
    end

    assign mem_pel.pix = mem_rd_pix;
    assign mem_pel.p32 = mem_rd_p32;
    assign mem_pel.ctl = mem_rd_ctl;

    pixop_seq #(.MEM_AW(MEM_AW), .MASK_W(MASK_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_stip_i   (go_stip),
        .go_blit_i   (go_blit),
        .raw_i       (req_win[1]),
        .deep_i      (deep_en),
        .dst_i       (MEM_AW'(req_addr[ADDR_W-1:3])),
        .src_i       (req_wdata[MEM_AW-1:0]),
        .len_m1_i    (req_wdata[MEM_AW +: LEN_W]),
        .mask_i      (req_wdata[MASK_W-1:0]),
        .color_i     (color_q),
        .mask_o      (mask_cur),
        .pick_off_i  (pick_off),
        .pick_rest_i (pick_rest),
        .copy_pel_i  (copy_pel),
        .busy_o      (busy),
        .rd_en_o     (mem_rd_en),
        .rd_addr_o   (mem_rd_addr),
        .wr_en_o     (mem_wr_en),
        .wr_addr_o   (mem_wr_addr),
        .wr_pel_o    (wr_pel),
        .wr_p32_en_o (mem_wr_p32_en),
        .wr_ctl_en_o (mem_wr_ctl_en)
    );

    pixop_bitpick #(.MASK_W(MASK_W)) u_pick (
        .mask_i (mask_cur),
        .any_o  (pick_any),
        .off_o  (pick_off),
        .rest_o (pick_rest)
    );

    pixop_fwd #(.MEM_AW(MEM_AW)) u_fwd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (mem_rd_en),
        .rd_addr_i (mem_rd_addr),
        .wr_en_i   (mem_wr_en),
        .wr_addr_i (mem_wr_addr),
        .wr_pel_i  (wr_pel),
        .mem_pel_i (mem_pel),
        .src_pel_o (copy_pel)
    );

    assign mem_wr_pix = wr_pel.pix;
    assign mem_wr_p32 = wr_pel.p32;
    assign mem_wr_ctl = wr_pel.ctl;

    // R3
    stip_has_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_stip && (req_wdata[MASK_W-1:0] != '0) |=> busy && pick_any);
    // R9
    ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_blit |=> busy && !req_ready);
    // R1
    color_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(color_q));
endmodule

// File: tb/pixop_engine_tb.sv
// Directed bench for pixop_engine with a three-plane pixel memory model.
module pixop_engine_tb;
    localparam int MSZ = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        deep_en = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_win = 2'd0;
    logic [22:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, busy;
    logic [31:0] rsp_rdata;
    logic        mem_rd_en, mem_wr_en, mem_wr_p32_en, mem_wr_ctl_en;
    logic [23:0] mem_rd_addr, mem_wr_addr;
    logic [7:0]  mem_rd_pix, mem_wr_pix;
    logic [31:0] mem_rd_p32, mem_rd_ctl, mem_wr_p32, mem_wr_ctl;

    int errors = 0, checks = 0, cyc = 0, act_cnt = 0;

    logic [7:0]  m_pix [MSZ];
    logic [31:0] m_p32 [MSZ];
    logic [31:0] m_ctl [MSZ];
    logic [7:0]  e_pix [MSZ];
    logic [31:0] e_p32 [MSZ];
    logic [31:0] e_ctl [MSZ];
    logic [31:0] e_col = '0;

    always #5 clk = ~clk;

    pixop_engine u_dut (
        .clk(clk), .rst_n(rst_n), .deep_en(deep_en),
        .req_valid(req_valid), .req_write(req_write), .req_win(req_win),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .busy(busy),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_pix(mem_rd_pix), .mem_rd_p32(mem_rd_p32), .mem_rd_ctl(mem_rd_ctl),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_pix(mem_wr_pix),
        .mem_wr_p32_en(mem_wr_p32_en), .mem_wr_p32(mem_wr_p32),
        .mem_wr_ctl_en(mem_wr_ctl_en), .mem_wr_ctl(mem_wr_ctl)
    );

    // Pixel memory: one-cycle read latency, read sees old data on collision
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_pix <= m_pix[mem_rd_addr[11:0]];
            mem_rd_p32 <= m_p32[mem_rd_addr[11:0]];
            mem_rd_ctl <= m_ctl[mem_rd_addr[11:0]];
        end
        if (mem_wr_en)     m_pix[mem_wr_addr[11:0]] <= mem_wr_pix;
        if (mem_wr_p32_en) m_p32[mem_wr_addr[11:0]] <= mem_wr_p32;
        if (mem_wr_ctl_en) m_ctl[mem_wr_addr[11:0]] <= mem_wr_ctl;
    end

    // Memory activity counter and watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd_en || mem_wr_en || mem_wr_p32_en || mem_wr_ctl_en)
            act_cnt <= act_cnt + 1;
        if (cyc == 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected fewer", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_mem(input string tag);
        int bad = -1;
        checks++;
        for (int i = MSZ - 1; i >= 0; i--)
            if (m_pix[i] !== e_pix[i] || m_p32[i] !== e_p32[i] || m_ctl[i] !== e_ctl[i])
                bad = i;
        if (bad >= 0) begin
            errors++;
            $display("FAIL %s: pixel %0d actual=%h/%h/%h expected=%h/%h/%h", tag, bad,
                     m_pix[bad], m_p32[bad], m_ctl[bad], e_pix[bad], e_p32[bad], e_ctl[bad]);
        end
    endtask

    task automatic bus_wr(input logic [1:0] win, input logic [22:0] addr, input logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_win = win; req_addr = addr; req_wdata = data;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic set_colour(input logic [31:0] c);
        bus_wr(2'd0, 23'h0, c);
        e_col = c;
    endtask

    // Reference: stipple
    task automatic m_stip(input logic raw, input int dst, input logic [31:0] mask);
        for (int k = 0; k < 32; k++) if (mask[31-k]) begin
            e_pix[dst+k] = e_col[7:0];
            if (deep_en) e_p32[dst+k] = {8'h00, e_col[23:0]};
            if (deep_en && raw) e_ctl[dst+k] = {8'h00, e_col[23:0]};
        end
    endtask

    // Reference: blit fill or ascending copy
    task automatic m_blit(input logic raw, input int dst, input logic [23:0] src, input int len);
        for (int k = 0; k < len; k++) begin
            if (&src) begin
                e_pix[dst+k] = e_col[7:0];
                if (deep_en) e_p32[dst+k] = {8'h00, e_col[23:0]};
                if (deep_en && raw) e_ctl[dst+k] = {8'h00, e_col[23:0]};
            end else begin
                e_pix[dst+k] = e_pix[int'(src)+k];
                if (deep_en) e_p32[dst+k] = e_p32[int'(src)+k];
                if (deep_en && raw) e_ctl[dst+k] = e_ctl[int'(src)+k];
            end
        end
    endtask

    task automatic do_stip(input string tag, input logic [1:0] win, input int dst,
                           input logic [31:0] mask);
        int n, a0;
        a0 = act_cnt;
        bus_wr(win, {dst[19:0], 3'b100}, mask);
        count_busy(n);
        m_stip(win[1], dst, mask);
        chk_mem({tag, " R3 stipple pixels"});
        chk({tag, " R3 busy cycles"}, n, $countones(mask));
        if (mask == 0) chk({tag, " R3 empty mask activity"}, act_cnt - a0, 0);
    endtask

    task automatic do_blit(input string tag, input logic [1:0] win, input int dst,
                           input logic [23:0] src, input int len);
        int n;
        bus_wr(win, {dst[19:0], 3'b100}, {3'b000, 5'(len - 1), src});
        if (busy) chk({tag, " R9 ready low while busy"}, req_ready, 0);
        count_busy(n);
        m_blit(win[1], dst, src, len);
        if (&src) begin
            chk_mem({tag, " R4 fill pixels"});
            chk({tag, " R4 busy cycles"}, n, len);
        end else begin
            chk_mem({tag, " R5 copy pixels"});
            chk({tag, " R5 busy cycles"}, n, len + 1);
        end
    endtask

    task automatic t_reset();
        chk("R9 reset busy", busy, 0);
        chk("R9 reset ready", req_ready, 1);
        chk("R9 reset no access", mem_wr_en | mem_rd_en, 0);
    endtask

    task automatic t_colour_only();
        int a0 = act_cnt;
        set_colour(32'h5A_C3D2E1);
        chk("R1 colour store busy", busy, 0);
        @(negedge clk);
        chk("R1 colour store no access", act_cnt - a0, 0);
        chk_mem("R1 memory untouched");
    endtask

    task automatic t_read();
        int a0 = act_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_win = 2'd1;
        req_addr = {20'd40, 3'b100}; req_wdata = 32'h0000_0000;
        chk("R8 read data zero", rsp_rdata, 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 read no busy", busy, 0);
        @(negedge clk);
        chk("R8 read no access", act_cnt - a0, 0);
        // colour must be unchanged: fill with it and compare
        do_blit("R8 colour kept", 2'd1, 3000, 24'hFFFFFF, 3);
    endtask

    initial begin
        for (int i = 0; i < MSZ; i++) begin
            m_pix[i] = 8'(i * 7 + 3);
            m_p32[i] = 32'(i) * 32'h0101_0101 ^ 32'hA5A5_0000;
            m_ctl[i] = ~32'(i);
            e_pix[i] = m_pix[i]; e_p32[i] = m_p32[i]; e_ctl[i] = m_ctl[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_colour_only();

        // Shallow mode: only the 8-bit plane may change (R6, R2)
        set_colour(32'h00_1122_33);
        do_stip("R2 sparse", 2'd0, 291, 32'h8000_0001);
        do_stip("dense", 2'd0, 400, 32'hF0F0_0F0F);
        do_stip("empty", 2'd2, 500, 32'h0);
        set_colour(32'hFF_4455_66);
        do_blit("fill len1", 2'd1, 600, 24'hFFFFFF, 1);
        do_blit("fill len32", 2'd3, 700, 24'hFFFFFF, 32);
        do_blit("copy disjoint", 2'd1, 800, 24'd100, 5);
        do_blit("copy up overlap", 2'd1, 201, 24'd200, 6);
        do_blit("copy down overlap", 2'd1, 299, 24'd300, 6);
        chk_mem("R6 shallow wide planes untouched");

        // Deep mode: wide plane, raw control plane (R6, R7)
        deep_en = 1'b1;
        set_colour(32'hEE_ABCD_EF);
        do_stip("R6 deep plain", 2'd0, 1000, 32'hC000_0003);
        do_stip("R7 deep raw", 2'd2, 1100, 32'h0F00_F00F);
        do_blit("R7 deep raw fill", 2'd3, 1200, 24'hFFFFFF, 9);
        do_blit("R6 deep plain copy", 2'd1, 1300, 24'd1200, 9);
        do_blit("R7 deep raw copy overlap", 2'd3, 1401, 24'd1400, 7);
        do_blit("R7 deep raw copy", 2'd3, 1500, 24'd1100, 32);
        t_read();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule